// File: doc/BRIEF.md
# Interrupt Control Register

This block is the 8-bit interrupt control register of a small microcontroller. It holds five enable bits and three sticky event flags. The flags record a timer overflow, a rising edge on an external interrupt pin, and a change on a 4-bit port nibble. It combines the enables, the flags and a summary request from a peripheral group into one interrupt request line for the CPU.

The CPU reaches the register over a simple single-cycle bus. Four mirrored addresses map to the same storage. A write loads all eight bits. A flag is cleared only by software writing a 0 to it. Hardware set events override a clearing write made in the same cycle. A flag latches whether or not it is enabled, so software must clear a stale flag before it enables the source.

Port change detection compares the live nibble against a reference copy. The reference is captured on every CPU read of the port, and it resets to 0. On the cycle of the port read itself, the comparison still uses the old reference.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset, readback bits 7 to 1 are 0 and bit 0 equals parameter PORT_FLAG_RST (default 0).
- R2: The register is selected when the address is 0x00B, 0x08B, 0x10B or 0x18B, and all four reach the same storage. A write at any other address has no effect, and a read at any other address returns 0x00.
- R3: Readback `bus_rdata` is combinational while `bus_rd` is high and the address is selected. A write loads all eight bits at the next clock edge. The bit positions are: 7 global enable, 6 peripheral enable, 5 timer enable, 4 pin enable, 3 port enable, 2 timer flag, 1 pin flag, 0 port flag.
- R4: A high `tmr_ovf` in a cycle sets bit 2 at that clock edge, whatever the enables are. Bit 2 then stays set until software writes it to 0.
- R5: A rising edge on `ext_pin` sets bit 1 at the third clock edge after the pin is first sampled high, whatever the enables are. Bit 1 then stays set until software writes it to 0.
- R6: In every cycle where `port_nib` differs from the reference, bit 0 sets at that clock edge. The reference is loaded from `port_nib` at a clock edge where `port_rd` is high, and it resets to 0.
- R7: When a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)). It is combinational from the register state and `periph_req`.
- R9: While bit 7 is 0, `irq` is 0 for every other bit pattern and every value of `periph_req`.
- R10: A pin that stays high, or that falls, does not set bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 9 | CPU bus address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Readback, 0 when not selected |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_nib | input | 4 | Upper port nibble, synchronous to clk |
| port_rd | input | 1 | CPU read of the port; captures the reference |
| periph_req | input | 1 | Summary request from the peripheral group |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Readback and `irq` are combinational, so they are sampled 1 ns after the falling edge at which the bus read or the `periph_req` change is driven. A write, a timer pulse and a port mismatch show up in the register one clock edge after they are driven. A pin edge shows up three edges after it is driven, and the bench samples one falling edge earlier to prove the flag is not yet set. All stimulus changes on falling edges, so every expected value is settled before it is sampled.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int CTL_W   = 8;
  localparam int FLG_W   = 3;
  // bit positions, decoded by software
  localparam int BIT_GLB = 7;
  localparam int BIT_PEN = 6;
  localparam int BIT_TEN = 5;
  localparam int BIT_XEN = 4;
  localparam int BIT_CEN = 3;
  localparam int BIT_TFL = 2;
  localparam int BIT_XFL = 1;
  localparam int BIT_CFL = 0;
  typedef logic [CTL_W-1:0] ctl_word_t;
endpackage

// File: rtl/irq_addr_match.sv
module irq_addr_match #(
  parameter int ADDR_W      = 9,
  parameter int OFFS_W      = 7,
  parameter int OFFSET      = 'h0B,
  parameter int NUM_MIRRORS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int BANK_W = ADDR_W - OFFS_W;
  logic offs_ok;
  logic bank_ok;

  assign offs_ok = (addr[OFFS_W-1:0] == OFFS_W'(OFFSET));

  generate
    if (BANK_W > 0) begin : g_bank
      assign bank_ok = ({1'b0, addr[ADDR_W-1:OFFS_W]} < (BANK_W+1)'(NUM_MIRRORS));
    end else begin : g_nobank
      assign bank_ok = 1'b1;
    end
  endgenerate

  assign hit = offs_ok & bank_ok;
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R5
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         snap,
  output logic         mismatch
);
  logic [W-1:0] ref_q;
  logic [W-1:0] ref_d;

  always_comb begin
    ref_d = ref_q;
    if (snap) ref_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '0;
    else if (snap) ref_q <= ref_d;
  end

  assign mismatch = (pins != ref_q);

  // R6
  ref_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (!mismatch || (pins != $past(pins))));
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int   ADDR_W        = 9,
  parameter int   PORT_W        = 4,
  parameter int   SYNC_STAGES   = 2,
  parameter int   REG_OFFSET    = 'h0B,
  parameter int   NUM_MIRRORS   = 4,
  parameter logic PORT_FLAG_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_nib,
  input  logic              port_rd,
  input  logic              periph_req,
  output logic              irq
);
  localparam int EN_W = CTL_W - FLG_W;

  logic            sel;
  logic            wr_hit;
  logic            pin_rise;
  logic            port_mismatch;
  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_d;
  logic [FLG_W-1:0] flg_q;
  logic [FLG_W-1:0] flg_d;
  logic [FLG_W-1:0] flg_set;
  ctl_word_t       word;

  irq_addr_match #(
    .ADDR_W(ADDR_W), .OFFS_W(7), .OFFSET(REG_OFFSET), .NUM_MIRRORS(NUM_MIRRORS)
  ) u_match (
    .addr(bus_addr), .hit(sel)
  );

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .din(ext_pin), .rise(pin_rise)
  );

  irq_port_watch #(.W(PORT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .pins(port_nib), .snap(port_rd),
    .mismatch(port_mismatch)
  );

  assign wr_hit = bus_wr & sel;

  always_comb begin
    flg_set = '0;
    flg_set[BIT_TFL] = tmr_ovf;
    flg_set[BIT_XFL] = pin_rise;
    flg_set[BIT_CFL] = port_mismatch;
    en_d  = wr_hit ? bus_wdata[CTL_W-1:FLG_W] : en_q;
    flg_d = (wr_hit ? bus_wdata[FLG_W-1:0] : flg_q) | flg_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= {{(FLG_W-1){1'b0}}, PORT_FLAG_RST};
    else        flg_q <= flg_d;
  end

  assign word      = {en_q, flg_q};
  assign bus_rdata = (bus_rd & sel) ? word : '0;

  assign irq = word[BIT_GLB] &
               ((word[BIT_TEN] & word[BIT_TFL]) |
                (word[BIT_XEN] & word[BIT_XFL]) |
                (word[BIT_CEN] & word[BIT_CFL]) |
                (word[BIT_PEN] & periph_req));

  // R4
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flg_q[BIT_TFL]);
  // R4
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[BIT_TFL] && !wr_hit) |=> flg_q[BIT_TFL]);
  // R5
  pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> flg_q[BIT_XFL]);
  // R6
  port_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_mismatch |=> flg_q[BIT_CFL]);
  // R2
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !tmr_ovf && !pin_rise && !port_mismatch) |=> $stable(word));
endmodule

// File: tb/sim_irq_ctl_reg.sv
`timescale 1ns/1ps
module sim_irq_ctl_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       tmr_ovf, ext_pin, port_rd, periph_req;
  logic [3:0] port_nib;
  logic       irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_ovf(tmr_ovf), .ext_pin(ext_pin), .port_nib(port_nib),
    .port_rd(port_rd), .periph_req(periph_req), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [8:0] a, input logic [7:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [7:0] d, input logic p);
    return d[7] & ((d[5] & d[2]) | (d[4] & d[1]) | (d[3] & d[0]) | (d[6] & p));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] mir [4];
    logic [3:0] pv;
    mir[0] = 9'h00B; mir[1] = 9'h08B; mir[2] = 9'h10B; mir[3] = 9'h18B;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tmr_ovf = 0; ext_pin = 0; port_nib = '0; port_rd = 0; periph_req = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd("R1", 9'h00B, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 R3 R8 R9 exhaustive sweep across mirrors
    for (int d = 0; d < 256; d++) begin
      wr(mir[d % 4], 8'(d));
      rd("R2 R3", mir[(d + 1) % 4], 8'(d));
      for (int p = 0; p < 2; p++) begin
        periph_req = p[0];
        #1;
        check(d[7] ? "R8" : "R9", {7'd0, irq}, {7'd0, exp_irq(8'(d), p[0])});
      end
      periph_req = 1'b0;
    end

    // R2 unselected addresses ignored
    wr(9'h00B, 8'hE8);
    wr(9'h00C, 8'hFF);
    wr(9'h04B, 8'h17);
    wr(9'h08A, 8'h00);
    rd("R2 keep", 9'h18B, 8'hE8);
    rd("R2 miss read", 9'h00C, 8'h00);
    wr(9'h10B, 8'h00);
    rd("R2 clear", 9'h00B, 8'h00);

    // R4 timer flag set without enables, sticky
    tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
    rd("R4 set", 9'h00B, 8'h04);
    repeat (5) step();
    rd("R4 hold", 9'h08B, 8'h04);
    wr(9'h00B, 8'h00);
    rd("R4 clear", 9'h00B, 8'h00);

    // R7 set beats clearing write
    step();
    bus_addr = 9'h00B; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
    step();
    bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd("R7", 9'h00B, 8'h04);
    wr(9'h00B, 8'h00);

    // R5 pin edge, three edges of latency
    ext_pin = 1'b1;
    step(); step();
    rd("R5 early", 9'h00B, 8'h00);
    step();
    rd("R5 set", 9'h00B, 8'h02);
    wr(9'h00B, 8'h00);
    repeat (6) step();
    rd("R10 steady high", 9'h00B, 8'h00);
    ext_pin = 1'b0;
    repeat (6) step();
    rd("R10 fall", 9'h00B, 8'h00);

    // R6 each port pin, reference update on port read
    pv = 4'h0;
    for (int i = 0; i < 4; i++) begin
      pv = pv ^ (4'h1 << i);
      port_nib = pv;
      step();
      rd("R6 set", 9'h00B, 8'h01);
      wr(9'h00B, 8'h00);
      rd("R7 port", 9'h00B, 8'h01);
      port_rd = 1'b1; step(); port_rd = 1'b0;
      wr(9'h00B, 8'h00);
      rd("R6 cleared", 9'h00B, 8'h00);
      repeat (3) step();
      rd("R6 quiet", 9'h00B, 8'h00);
    end

    // R8 port source with enables
    wr(9'h00B, 8'h88);
    check("R8 no flag", {7'd0, irq}, 8'h00);
    port_nib = 4'h0;
    step();
    rd("R6 back", 9'h00B, 8'h89);
    check("R8 port irq", {7'd0, irq}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule